// File: doc/BRIEF.md
# Burst SRAM access sequencer

This block runs one synchronous burst SRAM bank on a 64-bit processor bus whose address and data phases never overlap. A transfer request arrives as a one-cycle start pulse that carries the byte address, a read/write flag, a burst/single flag and a byte-lane mask. The sequencer then issues an address-strobe setup cycle, waits out the SRAM's first-access latency, and moves either four 64-bit beats (burst) or one beat (single). Each beat is reported to the bus with a transfer acknowledge.

Burst SRAMs keep reading or writing on every clock until told to stop. A read can be silenced through the output enable, but a write cannot. The sequencer therefore closes every access, read or write, with a deselect cycle. In that cycle the address strobe is asserted while chip enable is negated. One clock later the block is idle and can take the next request. Streaming bursts back to back is not supported: each access runs its own setup sequence.

Top module: `bsram_seq`

## Requirements
- R1: During and after reset, with no access accepted, the outputs are quiet: `sram_ads_n_o`, `sram_ce_n_o`, `sram_oe_n_o` and `sram_adv_n_o` are 1, `sram_bwe_n_o` is all ones, and `ack_o` is 0.
- R2: A start sampled while idle is accepted. The next cycle is the setup cycle, with `sram_ads_n_o`=0, `sram_ce_n_o`=0 and `ack_o`=0. Chip enable stays 0 from the setup cycle through the last beat.
- R3: With the start cycle counted as cycle 0, `ack_o` is first 1 in cycle 3. It then stays 1 for 4 consecutive cycles for a burst (`burst_i`=1), or for exactly 1 cycle for a single access (`burst_i`=0).
- R4: `sram_adv_n_o` is 0 only during burst beats two, three and four. It is 1 during the first beat, during every single access, and during the deselect cycle.
- R5: The cycle right after the last acknowledged beat is the deselect cycle: `sram_ads_n_o`=0, `sram_ce_n_o`=1, `sram_oe_n_o`=1, `sram_bwe_n_o` all ones, `ack_o`=0. This holds for reads and writes alike.
- R6: On a read (`wr_i`=0), `sram_oe_n_o` is 0 from cycle 2 through the last beat and 1 at all other times, and `sram_bwe_n_o` stays all ones.
- R7: On a write (`wr_i`=1), `sram_oe_n_o` stays 1 and `sram_bwe_n_o` is active only during beats. For a burst all eight lanes are driven 0. For a single access, bit i is the inverse of bit i of the `be_i` value captured at the start, where lane i carries data bits 8i+7..8i.
- R8: A start presented at any time from the setup cycle through the deselect cycle is ignored. It adds no acknowledge and no setup cycle. A start in the cycle right after the deselect cycle is accepted.
- R9: `sram_a_o` equals `addr_i[31:3]` as captured at the start, and holds that value from the setup cycle through the deselect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer start request, sampled while idle |
| addr_i | input | 32 | Byte address of the transfer |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| be_i | input | 8 | Byte-lane enables for a single write, 1 = lane written |
| sram_a_o | output | 29 | 64-bit word address to the SRAM |
| sram_ads_n_o | output | 1 | Active-low address strobe |
| sram_ce_n_o | output | 1 | Active-low chip enable |
| sram_oe_n_o | output | 1 | Active-low output enable |
| sram_bwe_n_o | output | 8 | Active-low byte-write enables |
| sram_adv_n_o | output | 1 | Active-low burst address advance |
| ack_o | output | 1 | Per-beat transfer acknowledge |

## Verification
The hardest case to reach from the ports is a start request that arrives in the deselect cycle itself. The address strobe is asserted in that cycle, so a sequencer that wrongly accepts the request would look almost correct. The stimulus holds `start_i` high with inverted flags from the setup cycle through the deselect cycle on every other access of the sweep. The bench then checks that the idle cycle is quiet, and starts the next access in that same idle cycle to show the request is accepted as soon as the block is idle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_SETUP = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_BEAT  = 3'd3,
    SQ_DESEL = 3'd4
  } sq_state_t;

  // Number of data beats one access moves.
  function automatic int unsigned beat_total(input logic burst, input int unsigned blen);
    return burst ? blen : 1;
  endfunction

  // The SRAM advances its internal address on every beat but the first.
  function automatic logic wants_advance(input sq_state_t st, input logic first_beat);
    return (st == SQ_BEAT) && !first_beat;
  endfunction

endpackage

// File: rtl/bsram_fsm.sv
module bsram_fsm
  import bsram_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned WAIT_CYC  = 1,
  localparam int unsigned CW = $clog2(BURST_LEN + 1),
  localparam int unsigned WW = $clog2(WAIT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          burst_i,
  output sq_state_t     state_o,
  output logic [CW-1:0] beat_o,
  output logic          burst_o,
  output logic          ev_accept_o,
  output logic          ev_last_beat_o
);

  sq_state_t     st, st_nx;
  logic [CW-1:0] beat;
  logic [WW-1:0] wcnt;
  logic          burst_q;
  logic          wait_done;

  assign ev_accept_o    = (st == SQ_IDLE) && start_i;
  assign wait_done      = (wcnt == WW'(WAIT_CYC - 1));
  assign ev_last_beat_o = (st == SQ_BEAT) &&
                          (beat == CW'(beat_total(burst_q, BURST_LEN) - 1));

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE:  if (start_i) st_nx = SQ_SETUP;
      SQ_SETUP: st_nx = SQ_WAIT;
      SQ_WAIT:  if (wait_done) st_nx = SQ_BEAT;
      SQ_BEAT:  if (ev_last_beat_o) st_nx = SQ_DESEL;
      SQ_DESEL: st_nx = SQ_IDLE;
      default:  st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      beat    <= '0;
      wcnt    <= '0;
      burst_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (ev_accept_o) burst_q <= burst_i;
      if (st == SQ_SETUP) wcnt <= '0;
      else if (st == SQ_WAIT && !wait_done) wcnt <= wcnt + 1'b1;
      if (st == SQ_WAIT) beat <= '0;
      else if (st == SQ_BEAT && !ev_last_beat_o) beat <= beat + 1'b1;
    end
  end

  assign state_o = st;
  assign beat_o  = beat;
  assign burst_o = burst_q;

endmodule

// File: rtl/bsram_capture.sv
module bsram_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 8,
  localparam int unsigned SH    = $clog2(LANES),
  localparam int unsigned SA_W  = ADDR_W - SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  be_i,
  output logic [SA_W-1:0]   word_o,
  output logic              wr_o,
  output logic [LANES-1:0]  be_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      wr_o   <= 1'b0;
      be_o   <= '0;
    end else if (take_i) begin
      word_o <= addr_i[ADDR_W-1:SH];
      wr_o   <= wr_i;
      be_o   <= be_i;
    end
  end

endmodule

// File: rtl/bsram_pins.sv
module bsram_pins
  import bsram_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned CW    = 3
) (
  input  sq_state_t        state_i,
  input  logic [CW-1:0]    beat_i,
  input  logic             burst_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  output logic             ads_n_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic [LANES-1:0] bwe_n_o,
  output logic             adv_n_o,
  output logic             ack_o
);

  function automatic logic [LANES-1:0] lane_strobes(input logic active, input logic burst,
                                                    input logic [LANES-1:0] be);
    if (!active) return '1;
    return burst ? '0 : ~be;
  endfunction

  logic in_beat, in_flight;

  assign in_beat   = (state_i == SQ_BEAT);
  assign in_flight = (state_i == SQ_SETUP) || (state_i == SQ_WAIT) || in_beat;

  assign ads_n_o = !((state_i == SQ_SETUP) || (state_i == SQ_DESEL));
  assign ce_n_o  = !in_flight;
  assign oe_n_o  = !(!wr_i && ((state_i == SQ_WAIT) || in_beat));
  assign bwe_n_o = lane_strobes(wr_i && in_beat, burst_i, be_i);
  assign adv_n_o = !wants_advance(state_i, beat_i == '0);
  assign ack_o   = in_beat;

endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LANES     = 8,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned WAIT_CYC  = 1,
  localparam int unsigned SA_W     = ADDR_W - $clog2(LANES),
  localparam int unsigned CW       = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              burst_i,
  input  logic [LANES-1:0]  be_i,
  output logic [SA_W-1:0]   sram_a_o,
  output logic              sram_ads_n_o,
  output logic              sram_ce_n_o,
  output logic              sram_oe_n_o,
  output logic [LANES-1:0]  sram_bwe_n_o,
  output logic              sram_adv_n_o,
  output logic              ack_o
);

  sq_state_t        st;
  logic [CW-1:0]    beat_idx;
  logic             burst_q, wr_q;
  logic [LANES-1:0] be_q;
  logic             ev_accept, ev_last_beat;

  bsram_fsm #(.BURST_LEN(BURST_LEN), .WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .burst_i        (burst_i),
    .state_o        (st),
    .beat_o         (beat_idx),
    .burst_o        (burst_q),
    .ev_accept_o    (ev_accept),
    .ev_last_beat_o (ev_last_beat)
  );

  bsram_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (ev_accept),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .be_i   (be_i),
    .word_o (sram_a_o),
    .wr_o   (wr_q),
    .be_o   (be_q)
  );

  bsram_pins #(.LANES(LANES), .CW(CW)) u_pins (
    .state_i (st),
    .beat_i  (beat_idx),
    .burst_i (burst_q),
    .wr_i    (wr_q),
    .be_i    (be_q),
    .ads_n_o (sram_ads_n_o),
    .ce_n_o  (sram_ce_n_o),
    .oe_n_o  (sram_oe_n_o),
    .bwe_n_o (sram_bwe_n_o),
    .adv_n_o (sram_adv_n_o),
    .ack_o   (ack_o)
  );

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SA_W  = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_accept,
  input logic             ev_last_beat,
  input logic [SA_W-1:0]  sram_a_o,
  input logic             sram_ads_n_o,
  input logic             sram_ce_n_o,
  input logic             sram_oe_n_o,
  input logic [LANES-1:0] sram_bwe_n_o,
  input logic             sram_adv_n_o,
  input logic             ack_o
);

  assert_setup_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (!sram_ads_n_o && !sram_ce_n_o && !ack_o));

  assert_ack_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (!sram_ce_n_o && sram_ads_n_o));

  assert_adv_trailing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_adv_n_o |-> (ack_o && $past(ack_o)));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_beat |=> (!sram_ads_n_o && sram_ce_n_o && sram_oe_n_o &&
                      (&sram_bwe_n_o) && sram_adv_n_o && !ack_o));

  assert_read_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n_o |-> ((&sram_bwe_n_o) && !sram_ce_n_o));

  assert_write_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sram_bwe_n_o) |-> (ack_o && sram_oe_n_o));

  assert_accept_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (sram_ce_n_o && sram_ads_n_o));

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_a_o));

endmodule

bind bsram_seq bsram_chk #(.LANES(LANES), .SA_W(SA_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_accept    (ev_accept),
  .ev_last_beat (ev_last_beat),
  .sram_a_o     (sram_a_o),
  .sram_ads_n_o (sram_ads_n_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_bwe_n_o (sram_bwe_n_o),
  .sram_adv_n_o (sram_adv_n_o),
  .ack_o        (ack_o)
);

// File: tb/test_bsram_seq.sv
module test_bsram_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        burst_i = 1'b0;
  logic [7:0]  be_i = '0;
  logic [28:0] sram_a_o;
  logic        sram_ads_n_o, sram_ce_n_o, sram_oe_n_o, sram_adv_n_o, ack_o;
  logic [7:0]  sram_bwe_n_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  bsram_seq i_bsram_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .wr_i(wr_i),
    .burst_i(burst_i), .be_i(be_i), .sram_a_o(sram_a_o), .sram_ads_n_o(sram_ads_n_o),
    .sram_ce_n_o(sram_ce_n_o), .sram_oe_n_o(sram_oe_n_o), .sram_bwe_n_o(sram_bwe_n_o),
    .sram_adv_n_o(sram_adv_n_o), .ack_o(ack_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, "ads_n", 64'(sram_ads_n_o), 64'd1);
    chk(req, "ce_n",  64'(sram_ce_n_o),  64'd1);
    chk(req, "oe_n",  64'(sram_oe_n_o),  64'd1);
    chk(req, "bwe_n", 64'(sram_bwe_n_o), 64'hff);
    chk(req, "adv_n", 64'(sram_adv_n_o), 64'd1);
    chk(req, "ack",   64'(ack_o),        64'd0);
  endtask

  // Called at a falling edge while the sequencer is idle; returns at the
  // falling edge of the idle cycle that follows the deselect cycle.
  task automatic access(input logic wr, input logic bst, input logic [31:0] a,
                        input logic [7:0] be, input logic noise);
    int nb    = bst ? 4 : 1;
    int desel = 3 + nb;
    start_i = 1'b1; wr_i = wr; burst_i = bst; addr_i = a; be_i = be;
    @(posedge clk);
    for (int k = 1; k <= desel + 1; k++) begin
      logic beat, e_ads, e_ce, e_oe, e_adv;
      logic [7:0] e_bwe;
      @(negedge clk);
      beat  = (k >= 3) && (k < desel);
      e_ads = !(k == 1 || k == desel);
      e_ce  = !(k < desel);
      e_oe  = !(!wr && k >= 2 && k < desel);
      e_adv = !(beat && k > 3);
      e_bwe = (wr && beat) ? (bst ? 8'h00 : ~be) : 8'hff;
      if (k == desel + 1) begin
        quiet("R8");
      end else begin
        chk(k == desel ? "R5" : "R2", $sformatf("ads_n k=%0d", k), 64'(sram_ads_n_o), 64'(e_ads));
        chk(k == desel ? "R5" : "R2", $sformatf("ce_n k=%0d", k),  64'(sram_ce_n_o),  64'(e_ce));
        chk("R6", $sformatf("oe_n k=%0d", k),  64'(sram_oe_n_o),  64'(e_oe));
        chk("R7", $sformatf("bwe_n k=%0d", k), 64'(sram_bwe_n_o), 64'(e_bwe));
        chk("R4", $sformatf("adv_n k=%0d", k), 64'(sram_adv_n_o), 64'(e_adv));
        chk("R3", $sformatf("ack k=%0d", k),   64'(ack_o),        64'(beat));
        chk("R9", $sformatf("addr k=%0d", k),  64'(sram_a_o),     64'(a >> 3));
      end
      // A request held through setup..deselect with other flags must be ignored.
      if (noise && k <= desel) begin
        start_i = 1'b1; wr_i = !wr; burst_i = !bst; addr_i = ~a; be_i = ~be;
      end else begin
        start_i = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    quiet("R1");                      // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    quiet("R1");                      // R1 after reset, nothing accepted
    for (int a = 0; a < 16; a++) begin
      logic [31:0] addr = 32'h1000_0000 ^ (32'(a) * 32'h0123_4568);
      logic [7:0]  be   = (8'h01 << (a % 8)) | ((a >= 8) ? 8'h30 : 8'h00);
      for (int m = 0; m < 4; m++) begin
        access(m[0], m[1], addr, be, a[0] ^ m[0]);
      end
    end
    // R8: a quiet idle cycle after the final access, with no stray acknowledge.
    @(negedge clk);
    quiet("R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule